// File: doc/BRIEF.md
# Two-Source Vectored Interrupt Controller

This block sits beside a small 8-bit processor core and decides when the core must call an interrupt routine. It has two request sources. One is a one-cycle overflow pulse from a timer. The other is an external pin, which passes through a synchronizer and is then watched for a rising or a falling transition. A polarity input, driven from an output-port level of the core, selects which transition counts. Each source has a sticky request flag and an enable bit. A master enable gates both sources. The enables and the flags live in one 8-bit register that the core reads and writes.

When the master enable is set, a source's flag and enable are both set, and the core's return stack has room, the block raises a one-cycle take strobe and presents the vector address of the winning source. On the clock edge that ends the strobe, the block clears the master enable and the serviced source's flag. This prevents nesting until software sets the master enable again. Requests that arrive while the master enable is clear stay latched and are serviced later. While the core is halted, a wake output is raised for any pending, enabled source.

Top module: `irq_vec_ctrl`

## Requirements
- R1: After reset the register reads 8'h00, and take and wake are both 0, even while halted is 1.
- R2: Register bit 0 is the master enable, bit 1 the external enable, bit 2 the timer enable, bit 4 the external flag and bit 5 the timer flag. All five are written directly and read back. Bits 3, 6 and 7 always read 0, whatever is written to them.
- R3: A high on tmr_ovf during a clock edge sets the timer flag (bit 5). The flag reads 1 after that edge.
- R4: The external flag (bit 4) is set by a pin edge. With edge_rise_sel high the edge is low-to-high, and with it low the edge is high-to-low. The edge of the other direction leaves the flag at 0. A pin change made before clock edge k shows in the flag after edge k+2.
- R5: take is 1 exactly when the master enable is 1, stack_full is 0, and some source has both its flag and its enable at 1. take follows the register state and the inputs in the same cycle. vec_addr is 8'h04 for an external take and 8'h08 for a timer take.
- R6: When both sources qualify at once, the external source wins and vec_addr is 8'h04.
- R7: The edge that ends a take strobe clears the master enable and the serviced flag, and leaves the other flag unchanged. As a result take lasts a single cycle.
- R8: A flag set while the master enable is 0 produces no take. It stays latched and produces a take once the master enable is written to 1.
- R9: While stack_full is 1, no take occurs and the register is not changed by acceptance. After stack_full falls, the pending request is taken.
- R10: A register write replaces all five bits, even in a take cycle. A hardware flag set in the same cycle still wins, so the flag ends at 1.
- R11: wake equals halted AND ((external enable AND external flag) OR (timer enable AND timer flag)). It does not depend on the master enable or on stack_full.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ext_pin | input | 1 | Asynchronous external request pin |
| edge_rise_sel | input | 1 | 1: rising edge of ext_pin triggers; 0: falling edge |
| tmr_ovf | input | 1 | One-cycle timer overflow pulse |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read value |
| stack_full | input | 1 | Core return stack is full; holds off acceptance |
| halted | input | 1 | Core is halted |
| take | output | 1 | One-cycle interrupt acceptance strobe |
| vec_addr | output | 8 | Vector address of the accepted source |
| wake | output | 1 | Wake request while halted |

## Verification
The bench sweeps every combination of the five register bits, stack_full and halted. For each combination it checks take, vector, wake and the register state after the strobe. A design with the wrong priority would vector to 8'h08 with both flags set. A design that cleared the wrong flag, or left the master enable set, would show the wrong register value and a strobe longer than one cycle. The pin path is checked for the three-edge latency and for each polarity, where a design that ignores the polarity select would latch the opposite transition. Write/set collisions and a take that coincides with a write are driven directly: a design that lets a write drop a same-cycle timer overflow loses the request, and one that lets the auto-clear beat the write leaves the wrong enables.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int REG_W   = 8;
  localparam int B_ME    = 0;
  localparam int B_EE    = 1;
  localparam int B_TE    = 2;
  localparam int B_EF    = 4;
  localparam int B_TF    = 5;

  typedef struct packed {
    logic tf;
    logic ef;
    logic te;
    logic ee;
    logic me;
  } irq_state_t;

  function automatic logic [REG_W-1:0] pack_reg(irq_state_t s);
    logic [REG_W-1:0] r;
    r = '0;
    r[B_ME] = s.me;
    r[B_EE] = s.ee;
    r[B_TE] = s.te;
    r[B_EF] = s.ef;
    r[B_TF] = s.tf;
    return r;
  endfunction

  function automatic logic next_flag(logic q, logic wr, logic wbit, logic set, logic clr);
    if (wr) return wbit | set;
    return (q & ~clr) | set;
  endfunction

  function automatic logic edge_hit(logic now, logic prev, logic rise_sel);
    return rise_sel ? (now & ~prev) : (~now & prev);
  endfunction
endpackage

// File: rtl/irq_edge_sync.sv
module irq_edge_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  input  logic rise_sel,
  output logic evt
);
  import irq_pkg::*;

  logic [SYNC_STAGES-1:0] chain;
  logic                   last_q;

  generate
    for (genvar i = 0; i < SYNC_STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[0] <= 1'b0;
          else        chain[0] <= pin;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[i] <= 1'b0;
          else        chain[i] <= chain[i-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) last_q <= 1'b0;
    else        last_q <= chain[SYNC_STAGES-1];
  end

  assign evt = edge_hit(chain[SYNC_STAGES-1], last_q, rise_sel);

  AST_EDGE_NOT_BACK_TO_BACK: assert property (@(posedge clk) disable iff (!rst_n)
    evt |=> (!evt || (rise_sel != $past(rise_sel)))); // R4
endmodule

// File: rtl/irq_ctrl_reg.sv
module irq_ctrl_reg (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr,
  input  irq_pkg::irq_state_t      wstate,
  input  logic                     ext_set,
  input  logic                     tmr_set,
  input  logic                     clr_me,
  input  logic                     clr_ext,
  input  logic                     clr_tmr,
  output irq_pkg::irq_state_t      st
);
  import irq_pkg::*;

  irq_state_t nxt;

  always_comb begin
    nxt    = st;
    nxt.me = wr ? wstate.me : (st.me & ~clr_me);
    nxt.ee = wr ? wstate.ee : st.ee;
    nxt.te = wr ? wstate.te : st.te;
    nxt.ef = next_flag(st.ef, wr, wstate.ef, ext_set, clr_ext);
    nxt.tf = next_flag(st.tf, wr, wstate.tf, tmr_set, clr_tmr);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st <= '0;
    else        st <= nxt;
  end

  AST_TMR_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    tmr_set |=> st.tf); // R10
  AST_EXT_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    ext_set |=> st.ef); // R4
  AST_TAKE_CLEARS_MASTER: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_me && !wr) |=> !st.me); // R7
  AST_TAKE_CLEARS_EXT: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_ext && !wr && !ext_set) |=> !st.ef); // R7
  AST_TAKE_CLEARS_TMR: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_tmr && !wr && !tmr_set) |=> !st.tf); // R7
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter #(
  parameter int               VEC_W   = 8,
  parameter logic [VEC_W-1:0] EXT_VEC = 'h04,
  parameter logic [VEC_W-1:0] TMR_VEC = 'h08
) (
  input  irq_pkg::irq_state_t st,
  input  logic                stack_full,
  input  logic                halted,
  output logic                take,
  output logic                take_ext,
  output logic                take_tmr,
  output logic [VEC_W-1:0]    vec,
  output logic                wake
);
  logic ext_rdy, tmr_rdy, gate;

  assign ext_rdy  = st.ee & st.ef;
  assign tmr_rdy  = st.te & st.tf;
  assign gate     = st.me & ~stack_full;
  assign take_ext = gate & ext_rdy;
  assign take_tmr = gate & tmr_rdy & ~ext_rdy;
  assign take     = take_ext | take_tmr;
  assign vec      = ext_rdy ? EXT_VEC : TMR_VEC;
  assign wake     = halted & (ext_rdy | tmr_rdy);
endmodule

// File: rtl/irq_vec_ctrl.sv
module irq_vec_ctrl #(
  parameter int                 SYNC_STAGES = 2,
  parameter int                 VEC_W       = 8,
  parameter logic [VEC_W-1:0]   EXT_VEC     = 'h04,
  parameter logic [VEC_W-1:0]   TMR_VEC     = 'h08
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ext_pin,
  input  logic             edge_rise_sel,
  input  logic             tmr_ovf,
  input  logic             reg_wr,
  input  logic [7:0]       reg_wdata,
  output logic [7:0]       reg_rdata,
  input  logic             stack_full,
  input  logic             halted,
  output logic             take,
  output logic [VEC_W-1:0] vec_addr,
  output logic             wake
);
  import irq_pkg::*;

  irq_state_t st, wstate;
  logic       ext_evt, take_ext, take_tmr;
  logic       wdata_unused;

  assign wdata_unused = ^{reg_wdata[7:6], reg_wdata[3]};

  assign wstate.me = reg_wdata[B_ME];
  assign wstate.ee = reg_wdata[B_EE];
  assign wstate.te = reg_wdata[B_TE];
  assign wstate.ef = reg_wdata[B_EF];
  assign wstate.tf = reg_wdata[B_TF];

  irq_edge_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .pin(ext_pin), .rise_sel(edge_rise_sel), .evt(ext_evt)
  );

  irq_ctrl_reg u_reg (
    .clk(clk), .rst_n(rst_n), .wr(reg_wr), .wstate(wstate),
    .ext_set(ext_evt), .tmr_set(tmr_ovf),
    .clr_me(take), .clr_ext(take_ext), .clr_tmr(take_tmr), .st(st)
  );

  irq_arbiter #(.VEC_W(VEC_W), .EXT_VEC(EXT_VEC), .TMR_VEC(TMR_VEC)) u_arb (
    .st(st), .stack_full(stack_full), .halted(halted),
    .take(take), .take_ext(take_ext), .take_tmr(take_tmr),
    .vec(vec_addr), .wake(wake)
  );

  assign reg_rdata = pack_reg(st);

  AST_TAKE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !reg_wr) |=> !take); // R7
  AST_EXT_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    (take && reg_rdata[B_EE] && reg_rdata[B_EF]) |-> (vec_addr == EXT_VEC)); // R6
  AST_FULL_HOLDS_STATE: assert property (@(posedge clk) disable iff (!rst_n)
    (stack_full && !reg_wr && !tmr_ovf && !ext_evt) |=> $stable(reg_rdata)); // R9
endmodule

// File: tb/irq_vec_ctrl_bench.sv
module irq_vec_ctrl_bench;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ext_pin = 1'b0, edge_rise_sel = 1'b1, tmr_ovf = 1'b0;
  logic       reg_wr = 1'b0;
  logic [7:0] reg_wdata = 8'h00;
  logic [7:0] reg_rdata;
  logic       stack_full = 1'b0, halted = 1'b0;
  logic       take, wake;
  logic [7:0] vec_addr;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_vec_ctrl u_irq_vec_ctrl (
    .clk(clk), .rst_n(rst_n), .ext_pin(ext_pin), .edge_rise_sel(edge_rise_sel),
    .tmr_ovf(tmr_ovf), .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .stack_full(stack_full), .halted(halted), .take(take), .vec_addr(vec_addr), .wake(wake)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("[TB] FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [7:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  function automatic logic [7:0] enc(bit me, bit ee, bit te, bit ef, bit tf);
    return 8'(me) | (8'(ee) << 1) | (8'(te) << 2) | (8'(ef) << 4) | (8'(tf) << 5);
  endfunction

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_tests++; n_fail++;
      $display("[TB] FAIL watchdog actual=0 expected=1");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    halted = 1'b1;
    repeat (3) @(negedge clk);
    chk(reg_rdata == 8'h00, "R1 reg", reg_rdata, 0);
    chk(take == 1'b0, "R1 take", take, 0);
    chk(wake == 1'b0, "R1 wake", wake, 0);
    rst_n = 1'b1;
    halted = 1'b0;
    @(negedge clk);

    // Sweep all register states x stack_full x halted (R2 R5 R6 R7 R9 R11)
    for (int c = 0; c < 32; c++) begin
      for (int m = 0; m < 4; m++) begin
        bit me, ee, te, ef, tf, sf, h, ae, at, tk;
        logic [7:0] cfg, after;
        me = c[0]; ee = c[1]; te = c[2]; ef = c[3]; tf = c[4];
        sf = m[0]; h = m[1];
        cfg = enc(me, ee, te, ef, tf);
        stack_full = sf; halted = h;
        wr_reg(cfg | 8'hC8);
        ae = ee & ef; at = te & tf;
        tk = me & ~sf & (ae | at);
        chk(reg_rdata == cfg, "R2 readback", reg_rdata, cfg);
        chk(take == tk, "R5 R9 take", take, tk);
        if (tk) chk(vec_addr == (ae ? 8'h04 : 8'h08), "R5 R6 vector", vec_addr, ae ? 4 : 8);
        chk(wake == (h & (ae | at)), "R11 wake", wake, h & (ae | at));
        after = cfg;
        if (tk) begin
          after[0] = 1'b0;
          if (ae) after[4] = 1'b0; else after[5] = 1'b0;
        end
        @(negedge clk);
        chk(reg_rdata == after, "R7 R9 post-take", reg_rdata, after);
        chk(take == 1'b0, "R7 single strobe", take, 0);
      end
    end
    stack_full = 1'b0; halted = 1'b0;

    // R3 timer pulse
    wr_reg(8'h00);
    tmr_ovf = 1'b1;
    @(negedge clk);
    tmr_ovf = 1'b0;
    chk(reg_rdata == 8'h20, "R3 timer flag", reg_rdata, 8'h20);
    chk(take == 1'b0, "R8 no take while master off", take, 0);

    // R8 latched request serviced when enabled
    wr_reg(8'h25);
    chk(take == 1'b1 && vec_addr == 8'h08, "R8 later take", {take, vec_addr}, 9'h108);

    // R4 rising edge with latency
    wr_reg(8'h00);
    edge_rise_sel = 1'b1;
    ext_pin = 1'b1;
    @(negedge clk); @(negedge clk);
    chk(reg_rdata[4] == 1'b0, "R4 latency early", reg_rdata[4], 0);
    @(negedge clk);
    chk(reg_rdata[4] == 1'b1, "R4 rising sets", reg_rdata[4], 1);
    wr_reg(8'h00);
    ext_pin = 1'b0;
    repeat (4) @(negedge clk);
    chk(reg_rdata[4] == 1'b0, "R4 falling ignored in rise mode", reg_rdata[4], 0);
    edge_rise_sel = 1'b0;
    @(negedge clk);
    ext_pin = 1'b1;
    repeat (4) @(negedge clk);
    chk(reg_rdata[4] == 1'b0, "R4 rising ignored in fall mode", reg_rdata[4], 0);
    ext_pin = 1'b0;
    @(negedge clk); @(negedge clk);
    chk(reg_rdata[4] == 1'b0, "R4 fall latency early", reg_rdata[4], 0);
    @(negedge clk);
    chk(reg_rdata[4] == 1'b1, "R4 falling sets", reg_rdata[4], 1);

    // R6 both pending: external then timer
    wr_reg(8'h37);
    chk(take == 1'b1 && vec_addr == 8'h04, "R6 external first", vec_addr, 4);
    @(negedge clk);
    chk(reg_rdata == 8'h26, "R7 keeps other flag", reg_rdata, 8'h26);
    wr_reg(8'h27);
    chk(take == 1'b1 && vec_addr == 8'h08, "R6 timer next", vec_addr, 8);

    // R9 stack full hold then release
    stack_full = 1'b1;
    wr_reg(8'h25);
    repeat (3) @(negedge clk);
    chk(take == 1'b0 && reg_rdata == 8'h25, "R9 held off", reg_rdata, 8'h25);
    stack_full = 1'b0;
    #1;
    chk(take == 1'b1 && vec_addr == 8'h08, "R9 taken after release", take, 1);
    @(negedge clk);
    chk(reg_rdata == 8'h04, "R9 cleared after release", reg_rdata, 8'h04);

    // R10 write vs same-cycle timer set
    @(negedge clk);
    reg_wr = 1'b1; reg_wdata = 8'h00; tmr_ovf = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0; tmr_ovf = 1'b0;
    chk(reg_rdata == 8'h20, "R10 hw set wins", reg_rdata, 8'h20);

    // R10 write during a take cycle overrides auto-clear
    wr_reg(8'h25);
    chk(take == 1'b1, "R10 take before write", take, 1);
    reg_wr = 1'b1; reg_wdata = 8'h05;
    @(negedge clk);
    reg_wr = 1'b0;
    chk(reg_rdata == 8'h05, "R10 write beats clear", reg_rdata, 8'h05);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule